// File: doc/BRIEF.md
# Buffered Line Error Counter Pair

This block keeps two event tallies for a single line channel. One tally counts line coding violations reported by an upstream decoder, and the other counts bit errors reported by an upstream pseudo-random sequence checker. Both arrive as single-cycle strobes in the recovered clock domain. The block does not detect the violations or check the sequence.

Each tally has a live counter and a holding buffer. The host sees only the buffer. A mode input chooses what refreshes the buffers. In manual mode a latch command triggers the refresh. In automatic mode each one-second tick triggers it. On a refresh, the live count moves into the buffer and the live counter restarts in the same cycle. A sticky flag records every one-second tick.

The host reads each buffer as two bytes. A low-byte read strobe captures the high byte, so the two bytes always come from the same 16-bit value.

Top module: `line_err_counters`

## Requirements
- R1: After reset, every byte output is 0x00 and `sec_flag` is 0.
- R2: The violation count rises by one for each cycle in which `cv_strobe` is high. The error count rises by one for each cycle in which `be_strobe` is high.
- R3: A cycle with `exz_strobe` high adds one to the violation count only when `exz_en` is high. If `cv_strobe` is also high in that cycle, the violation count rises by two.
- R4: In manual mode (`auto_mode` = 0), `latch_cmd` high at one clock edge moves both live counts into their buffers at the next edge. The new values are visible after that second edge. The live counts restart from zero, and a strobe sampled at the transfer edge is counted in the new interval.
- R5: In automatic mode (`auto_mode` = 1), the transfer happens at the edge where `sec_tick` is high, and `latch_cmd` has no effect on the buffers.
- R6: In manual mode, `sec_tick` does not change either buffer.
- R7: `sec_flag` goes to 1 at the edge after `sec_tick` is high. It goes to 0 at the edge after `flag_clr` is high. If both are high in the same cycle, the flag is set.
- R8: A live count stops at 0xFFFF instead of wrapping.
- R9: The low-byte output shows bits 7:0 of the buffer. The high-byte output holds bits 15:8 of the buffer as captured at the last edge where that counter's low-read strobe was high, and it changes at no other time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered line clock |
| rst | input | 1 | Synchronous reset, active high |
| cv_strobe | input | 1 | One coding violation this cycle |
| exz_strobe | input | 1 | One excessive-zero string this cycle |
| exz_en | input | 1 | Count excessive-zero strings as violations |
| be_strobe | input | 1 | One sequence bit error this cycle |
| sec_tick | input | 1 | One-second timer expiry pulse |
| auto_mode | input | 1 | 1: refresh on tick, 0: refresh on command |
| latch_cmd | input | 1 | Host latch command (manual mode) |
| flag_clr | input | 1 | Clear the tick flag |
| rd_lo_cv | input | 1 | Violation buffer low-byte read strobe |
| rd_lo_be | input | 1 | Error buffer low-byte read strobe |
| cv_lo | output | 8 | Violation buffer bits 7:0 |
| cv_hi | output | 8 | Captured violation buffer bits 15:8 |
| be_lo | output | 8 | Error buffer bits 7:0 |
| be_hi | output | 8 | Captured error buffer bits 15:8 |
| sec_flag | output | 1 | Sticky one-second tick flag |

## Verification
The live counters are hidden, so a wrong live count can only be seen at the next transfer. That transfer comes two edges after a latch command, or at a tick edge, and at that point the low byte disagrees with the number of strobes applied. A missed clear or a wrong saturation shows up one interval later, as a carried-over or wrapped value. A fault in the high-byte capture shows up after the next low-read strobe, or as a high byte that changes while no read is in progress.

// File: rtl/lec_pkg.sv
package lec_pkg;
  // per-cycle increment: up to two events may arrive together
  typedef logic [1:0] ev_inc_t;
  localparam int N_CNT = 2;
  localparam int IDX_CV = 0;
  localparam int IDX_BE = 1;
endpackage

// File: rtl/lec_ctrl.sv
module lec_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic auto_mode,
  input  logic latch_cmd,
  input  logic sec_tick,
  input  logic flag_clr,
  output logic xfer,
  output logic sec_flag
);
  logic cmd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q    <= 1'b0;
      sec_flag <= 1'b0;
    end else begin
      cmd_q <= latch_cmd;
      if (sec_tick)      sec_flag <= 1'b1;
      else if (flag_clr) sec_flag <= 1'b0;
    end
  end

  // transfer source chosen by the mode in the transfer cycle
  assign xfer = auto_mode ? sec_tick : cmd_q;
endmodule

// File: rtl/lec_counter.sv
module lec_counter
  import lec_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  ev_inc_t             inc,
  input  logic                xfer,
  input  logic                rd_lo,
  output logic [BYTE_W-1:0]   lo_byte,
  output logic [CNT_W-BYTE_W-1:0] hi_byte
);
  localparam int HI_W = CNT_W - BYTE_W;

  logic [CNT_W-1:0] live_q;
  logic [CNT_W-1:0] buf_q;
  logic [HI_W-1:0]  hi_q;
  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] live_nx;

  always_comb begin
    sum = {1'b0, live_q} + {{(CNT_W-1){1'b0}}, inc};
    live_nx = sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q <= '0;
      buf_q  <= '0;
      hi_q   <= '0;
    end else begin
      if (xfer) begin
        buf_q  <= live_q;
        live_q <= {{(CNT_W-2){1'b0}}, inc};
      end else begin
        live_q <= live_nx;
      end
      if (rd_lo) hi_q <= buf_q[CNT_W-1:BYTE_W];
    end
  end

  assign lo_byte = buf_q[BYTE_W-1:0];
  assign hi_byte = hi_q;
endmodule

// File: rtl/line_err_counters.sv
module line_err_counters
  import lec_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cv_strobe,
  input  logic                    exz_strobe,
  input  logic                    exz_en,
  input  logic                    be_strobe,
  input  logic                    sec_tick,
  input  logic                    auto_mode,
  input  logic                    latch_cmd,
  input  logic                    flag_clr,
  input  logic                    rd_lo_cv,
  input  logic                    rd_lo_be,
  output logic [BYTE_W-1:0]       cv_lo,
  output logic [CNT_W-BYTE_W-1:0] cv_hi,
  output logic [BYTE_W-1:0]       be_lo,
  output logic [CNT_W-BYTE_W-1:0] be_hi,
  output logic                    sec_flag
);
  localparam int HI_W = CNT_W - BYTE_W;

  logic    xfer;
  ev_inc_t inc_a [N_CNT];
  logic    rd_a  [N_CNT];
  logic [BYTE_W-1:0] lo_a [N_CNT];
  logic [HI_W-1:0]   hi_a [N_CNT];

  always_comb begin
    inc_a[IDX_CV] = {1'b0, cv_strobe} + {1'b0, exz_en & exz_strobe};
    inc_a[IDX_BE] = {1'b0, be_strobe};
    rd_a[IDX_CV]  = rd_lo_cv;
    rd_a[IDX_BE]  = rd_lo_be;
  end

  lec_ctrl u_ctrl (
    .clk(clk), .rst(rst), .auto_mode(auto_mode), .latch_cmd(latch_cmd),
    .sec_tick(sec_tick), .flag_clr(flag_clr), .xfer(xfer), .sec_flag(sec_flag)
  );

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    lec_counter #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_cnt (
      .clk(clk), .rst(rst), .inc(inc_a[g]), .xfer(xfer), .rd_lo(rd_a[g]),
      .lo_byte(lo_a[g]), .hi_byte(hi_a[g])
    );
  end

  assign cv_lo = lo_a[IDX_CV];
  assign cv_hi = hi_a[IDX_CV];
  assign be_lo = lo_a[IDX_BE];
  assign be_hi = hi_a[IDX_BE];
endmodule

// File: rtl/lec_chk.sv
module lec_chk #(
  parameter int LO_W = 8,
  parameter int HI_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            sec_tick,
  input logic            auto_mode,
  input logic            latch_cmd,
  input logic            flag_clr,
  input logic            rd_lo_cv,
  input logic            rd_lo_be,
  input logic [LO_W-1:0] cv_lo,
  input logic [HI_W-1:0] cv_hi,
  input logic [LO_W-1:0] be_lo,
  input logic [HI_W-1:0] be_hi,
  input logic            sec_flag
);
  assert_hi_frozen_cv_R9: assert property (@(posedge clk) disable iff (rst)
    !rd_lo_cv |=> $stable(cv_hi));
  assert_hi_frozen_be_R9: assert property (@(posedge clk) disable iff (rst)
    !rd_lo_be |=> $stable(be_hi));
  assert_tick_sets_flag_R7: assert property (@(posedge clk) disable iff (rst)
    sec_tick |=> sec_flag);
  assert_clr_drops_flag_R7: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !sec_tick) |=> !sec_flag);
  assert_auto_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (auto_mode && !sec_tick) |=> ($stable(cv_lo) && $stable(be_lo)));
  assert_manual_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!auto_mode && !$past(latch_cmd)) |=> ($stable(cv_lo) && $stable(be_lo)));
endmodule

bind line_err_counters lec_chk #(.LO_W(BYTE_W), .HI_W(CNT_W-BYTE_W)) u_chk (
  .clk(clk), .rst(rst), .sec_tick(sec_tick), .auto_mode(auto_mode),
  .latch_cmd(latch_cmd), .flag_clr(flag_clr), .rd_lo_cv(rd_lo_cv),
  .rd_lo_be(rd_lo_be), .cv_lo(cv_lo), .cv_hi(cv_hi), .be_lo(be_lo),
  .be_hi(be_hi), .sec_flag(sec_flag)
);

// File: tb/line_err_counters_test.sv
module line_err_counters_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cv_strobe = 0, exz_strobe = 0, exz_en = 0, be_strobe = 0;
  logic sec_tick = 0, auto_mode = 0, latch_cmd = 0, flag_clr = 0;
  logic rd_lo_cv = 0, rd_lo_be = 0;
  logic [7:0] cv_lo, cv_hi, be_lo, be_hi;
  logic sec_flag;
  int n_chk = 0, n_bad = 0;
  logic [15:0] v;

  always #(CLK_P/2) clk = ~clk;

  line_err_counters uut (
    .clk(clk), .rst(rst), .cv_strobe(cv_strobe), .exz_strobe(exz_strobe),
    .exz_en(exz_en), .be_strobe(be_strobe), .sec_tick(sec_tick),
    .auto_mode(auto_mode), .latch_cmd(latch_cmd), .flag_clr(flag_clr),
    .rd_lo_cv(rd_lo_cv), .rd_lo_be(rd_lo_be), .cv_lo(cv_lo), .cv_hi(cv_hi),
    .be_lo(be_lo), .be_hi(be_hi), .sec_flag(sec_flag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic nclk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_cv(input int n);
    cv_strobe = 1; nclk(n); cv_strobe = 0;
  endtask

  task automatic pulse_be(input int n);
    be_strobe = 1; nclk(n); be_strobe = 0;
  endtask

  task automatic do_latch();
    latch_cmd = 1; nclk(1); latch_cmd = 0; nclk(1);
  endtask

  task automatic read_cv(output logic [15:0] r);
    logic [7:0] lo;
    lo = cv_lo; rd_lo_cv = 1; nclk(1); rd_lo_cv = 0;
    r = {cv_hi, lo};
  endtask

  task automatic read_be(output logic [15:0] r);
    logic [7:0] lo;
    lo = be_lo; rd_lo_be = 1; nclk(1); rd_lo_be = 0;
    r = {be_hi, lo};
  endtask

  initial begin
    #(CLK_P*200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    nclk(3); rst = 0; nclk(1);
    // R1 reset state
    chk("R1 cv", {cv_hi, cv_lo}, 0);
    chk("R1 be", {be_hi, be_lo}, 0);
    chk("R1 flag", sec_flag, 0);

    // R2 / R4 sweep in manual mode
    for (int n = 0; n <= 20; n++) begin
      pulse_cv(n);
      pulse_be((n*3) % 17);
      do_latch();
      read_cv(v); chk("R2 R4 cv sweep", v, n);
      read_be(v); chk("R2 R4 be sweep", v, (n*3) % 17);
    end

    // R3 excessive-zero strings
    exz_en = 0; exz_strobe = 1; nclk(5); exz_strobe = 0;
    do_latch(); read_cv(v); chk("R3 exz disabled", v, 0);
    exz_en = 1; exz_strobe = 1; cv_strobe = 1; nclk(4);
    exz_strobe = 0; cv_strobe = 0; exz_en = 0;
    do_latch(); read_cv(v); chk("R3 exz enabled double", v, 8);

    // R4 event in the transfer cycle goes to the new interval
    pulse_cv(3);
    latch_cmd = 1; nclk(1); latch_cmd = 0; cv_strobe = 1; nclk(1); cv_strobe = 0;
    read_cv(v); chk("R4 old interval", v, 3);
    do_latch(); read_cv(v); chk("R4 new interval", v, 1);

    // R6 / R7 tick in manual mode
    pulse_cv(5);
    sec_tick = 1; nclk(1); sec_tick = 0;
    chk("R6 tick no transfer", cv_lo, 1);
    chk("R7 flag set", sec_flag, 1);
    flag_clr = 1; nclk(1); flag_clr = 0;
    chk("R7 flag cleared", sec_flag, 0);
    flag_clr = 1; sec_tick = 1; nclk(1); flag_clr = 0; sec_tick = 0;
    chk("R7 set wins", sec_flag, 1);
    flag_clr = 1; nclk(1); flag_clr = 0;
    do_latch(); read_cv(v); chk("R6 count kept", v, 5);

    // R5 automatic mode
    auto_mode = 1;
    pulse_cv(7); pulse_be(2);
    do_latch();
    chk("R5 latch ignored", cv_lo, 5);
    pulse_cv(1);
    sec_tick = 1; nclk(1); sec_tick = 0;
    read_cv(v); chk("R5 tick transfer cv", v, 8);
    read_be(v); chk("R5 tick transfer be", v, 2);
    auto_mode = 0;
    do_latch(); read_cv(v); chk("R5 cleared after tick", v, 0);

    // R9 high byte capture
    pulse_cv(300); do_latch(); read_cv(v); chk("R9 first value", v, 300);
    pulse_cv(600); do_latch();
    chk("R9 hi frozen", cv_hi, 8'h01);
    chk("R9 lo live", cv_lo, 8'h58);
    read_cv(v); chk("R9 hi after read", v, 600);

    // R8 saturation
    pulse_cv(65600); do_latch(); read_cv(v); chk("R8 saturate", v, 16'hFFFF);
    do_latch(); read_cv(v); chk("R8 restart", v, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule